// File: doc/BRIEF.md
# DAC Channel Offset and Gain Trim Sequencer

This block calibrates a multi-channel DAC one channel at a time. For each channel it selects the channel onto the shared monitor path. It loads the two trim registers with their neutral values. It then drives the lowest code and asks an external ADC for a reading, already expressed in DAC LSB units. The deviation from the expected zero becomes a whole-LSB correction of the offset trim. Only after that correction has been written does it drive the full-scale code and take a second reading. The deviation from full scale minus one LSB becomes a whole-LSB correction of the gain trim.

When every channel has been trimmed, the block raises `done`. In one-shot use, for example trimming once at power-up, it then stays idle until the next `start`. With `periodic` set, it starts a new sweep by itself after a programmable number of idle cycles, so the trims can follow drift in the signal chain.

All writes to the DAC leave through one port. A kind field on that port says whether the data is a channel code, an offset trim or a gain trim.

Top module: `dac_trim_sequencer`

## Requirements
- R1: After reset, `wr_en`, `adc_req` and `done` are low and `ch_sel` is 0, and nothing is written until `start` is seen.
- R2: A sweep begins at channel 0. For each channel it first writes the offset trim default 8192 (kind 1) and then the gain trim default 16382 (kind 2), before any measurement. The kind codes are 0 for a channel code, 1 for the offset trim and 2 for the gain trim.
- R3: The offset phase writes channel code 0 (kind 0) and, in the next cycle, raises `adc_req` for exactly one cycle.
- R4: On an ADC reading E taken in the offset phase, the offset trim written is 8192 − E. The write occurs in the cycle after the one in which `adc_valid` is high.
- R5: The gain phase starts only after the offset trim write. It writes code 16383 (kind 0) and then pulses `adc_req` for one cycle.
- R6: On a reading F taken in the gain phase, with full scale minus one LSB (16383) as the expected value, the gain trim written is 16382 − (F − 16383).
- R7: A negative error raises a trim. Each trim result is clamped to the range 0 to 16383.
- R8: Channels are processed in ascending order. `ch_sel` holds the channel number for all six writes of that channel.
- R9: `done` rises in the cycle after the last channel's gain trim write. While `done` is high, nothing is written and no reading is requested.
- R10: With `periodic` high, a new sweep starts after `done` has been high for `interval` cycles. With `periodic` low, `done` stays high until `start`.
- R11: The sequencer waits as long as needed for `adc_valid`. An `adc_valid` pulse that arrives while no reading is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sweep when idle or done |
| periodic | input | 1 | Repeat sweeps automatically |
| interval | input | IVL_W | Cycles spent in done before an automatic sweep |
| ch_sel | output | CHW | Channel under calibration, also the monitor select |
| wr_en | output | 1 | DAC write strobe |
| wr_kind | output | 2 | 0 code, 1 offset trim, 2 gain trim |
| wr_data | output | CODE_W | Value written |
| adc_req | output | 1 | One-cycle measurement request |
| adc_valid | input | 1 | Reading available |
| adc_data | input | ADC_W | Signed reading in DAC LSB units |
| done | output | 1 | All channels calibrated |

## Verification
Each trim write is due exactly one cycle after the cycle in which `adc_valid` is high. `done` is due one cycle after the final gain trim write, and an automatic restart is due after exactly `interval` cycles of `done`. The monitor samples at the falling edge. It compares every write in order against a queue filled from the requirements, and it records the cycle of each valid and each write so that these one-cycle and `interval`-cycle distances can be checked directly. The ADC model answers after a latency that varies by channel, so the wait-for-valid behaviour is exercised across short and long delays.

// File: rtl/dac_trim_sequencer.sv
module dac_trim_sequencer #(
  parameter int NCH    = 16,
  parameter int CODE_W = 14,
  parameter int ADC_W  = 18,
  parameter int IVL_W  = 16,
  parameter int CHW    = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    periodic,
  input  logic [IVL_W-1:0]        interval,
  output logic [CHW-1:0]          ch_sel,
  output logic                    wr_en,
  output logic [1:0]              wr_kind,
  output logic [CODE_W-1:0]       wr_data,
  output logic                    adc_req,
  input  logic                    adc_valid,
  input  logic signed [ADC_W-1:0] adc_data,
  output logic                    done
);
  localparam int SW = ADC_W + 3;
  localparam logic [CODE_W-1:0] FULL  = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] C_DEF = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] M_DEF = FULL - 1'b1;
  localparam logic signed [SW-1:0] FULL_S = SW'(FULL);
  localparam logic signed [SW-1:0] C_S    = SW'(C_DEF);
  localparam logic signed [SW-1:0] M_S    = SW'(M_DEF);
  localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

  typedef enum logic [3:0] {
    IDLE, LD_C, LD_M, SET_LO, REQ_LO, WAIT_LO, PUT_C,
    SET_HI, REQ_HI, WAIT_HI, PUT_M, DONE
  } state_t;

  state_t state, nxt;
  logic [CODE_W-1:0] trim;
  logic [IVL_W-1:0]  cnt;
  logic signed [SW-1:0] dev, raw;
  logic hi, expire, go;

  assign hi  = (state == WAIT_HI);
  assign dev = {{3{adc_data[ADC_W-1]}}, adc_data} - (hi ? FULL_S : '0);
  assign raw = (hi ? M_S : C_S) - dev;
  assign expire = ({1'b0, cnt} + 1'b1) >= {1'b0, interval};
  assign go = start || (periodic && expire);

  always_comb begin
    nxt = state;
    case (state)
      IDLE:    if (start) nxt = LD_C;
      LD_C:    nxt = LD_M;
      LD_M:    nxt = SET_LO;
      SET_LO:  nxt = REQ_LO;
      REQ_LO:  nxt = WAIT_LO;
      WAIT_LO: if (adc_valid) nxt = PUT_C;
      PUT_C:   nxt = SET_HI;
      SET_HI:  nxt = REQ_HI;
      REQ_HI:  nxt = WAIT_HI;
      WAIT_HI: if (adc_valid) nxt = PUT_M;
      PUT_M:   nxt = (ch_sel == LAST_CH) ? DONE : LD_C;
      DONE:    if (go) nxt = LD_C;
      default: nxt = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IDLE;
      ch_sel <= '0;
      trim   <= '0;
      cnt    <= '0;
    end else begin
      state <= nxt;
      if ((state == WAIT_LO || state == WAIT_HI) && adc_valid) begin
        if (raw < 0)           trim <= '0;
        else if (raw > FULL_S) trim <= FULL;
        else                   trim <= raw[CODE_W-1:0];
      end
      if (state == PUT_M && ch_sel != LAST_CH) ch_sel <= ch_sel + 1'b1;
      if ((state == IDLE && start) || (state == DONE && go)) ch_sel <= '0;
      if (state == DONE) cnt <= cnt + 1'b1;
      else               cnt <= '0;
    end
  end

  assign wr_en = (state == LD_C) || (state == LD_M) || (state == SET_LO) ||
                 (state == PUT_C) || (state == SET_HI) || (state == PUT_M);
  assign wr_kind = (state == LD_C || state == PUT_C) ? 2'd1 :
                   (state == LD_M || state == PUT_M) ? 2'd2 : 2'd0;
  always_comb begin
    case (state)
      LD_C:    wr_data = C_DEF;
      LD_M:    wr_data = M_DEF;
      SET_HI:  wr_data = FULL;
      PUT_C,
      PUT_M:   wr_data = trim;
      default: wr_data = '0;
    endcase
  end
  assign adc_req = (state == REQ_LO) || (state == REQ_HI);
  assign done    = (state == DONE);

  assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req |=> !adc_req);
  assert_low_code_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == REQ_LO) |-> $past(wr_en && wr_kind == 2'd0 && wr_data == '0));
  assert_trim_follows_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WAIT_LO && adc_valid) |=> (wr_en && wr_kind == 2'd1));
  assert_gain_after_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SET_HI) |-> $past(wr_en && wr_kind == 2'd1));
  assert_ch_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != IDLE && state != DONE && state != LD_C) |-> $stable(ch_sel));
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wr_en && !adc_req));
endmodule

// File: tb/dac_trim_sequencer_bench.sv
module dac_trim_sequencer_bench;
  localparam int NCH = 16;
  localparam int CHW = 4;

  logic clk = 0, rst_n = 0, start = 0, periodic = 0;
  logic [15:0] interval = 16'd25;
  logic [CHW-1:0] ch_sel;
  logic wr_en, adc_req, adc_valid = 0, done;
  logic [1:0] wr_kind;
  logic [13:0] wr_data;
  logic signed [17:0] adc_data = 0;

  dac_trim_sequencer u_dac_trim_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .periodic(periodic),
    .interval(interval), .ch_sel(ch_sel), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_data(wr_data), .adc_req(adc_req), .adc_valid(adc_valid),
    .adc_data(adc_data), .done(done));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int last_m_cyc = -10, last_valid_cyc = -10;
  bit finished = 0;
  logic [23:0] exp_q[$];
  string tag_q[$];
  int offs[NCH], gains[NCH];
  logic [13:0] last_code;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clampi(input int v);
    return v < 0 ? 0 : (v > 16383 ? 16383 : v);
  endfunction

  task automatic push_sweep();
    for (int c = 0; c < NCH; c++) begin
      int ce = clampi(8192 - offs[c]);
      int me = clampi(16382 - gains[c]);
      exp_q.push_back({8'(c), 2'd1, 14'd8192});  tag_q.push_back("R2");
      exp_q.push_back({8'(c), 2'd2, 14'd16382}); tag_q.push_back("R2");
      exp_q.push_back({8'(c), 2'd0, 14'd0});     tag_q.push_back("R3");
      exp_q.push_back({8'(c), 2'd1, 14'(ce)});
      tag_q.push_back((ce == 0 || ce == 16383) ? "R7" : "R4");
      exp_q.push_back({8'(c), 2'd0, 14'd16383}); tag_q.push_back("R5");
      exp_q.push_back({8'(c), 2'd2, 14'(me)});
      tag_q.push_back((me == 0 || me == 16383) ? "R7" : "R6");
    end
  endtask

  // monitor / scoreboard (R8 via channel field)
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      logic [23:0] got, e;
      string t;
      got = {8'(ch_sel), wr_kind, wr_data};
      if (exp_q.size() == 0) begin
        check(0, "R9", int'(got), -1);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got == e, {t, "/R8"}, int'(got), int'(e));
        if (t != "R2" && wr_kind != 2'd0)
          check(last_valid_cyc == cyc - 1, "R4", last_valid_cyc, cyc - 1);
      end
      if (wr_kind == 2'd0) last_code = wr_data;
      if (wr_kind == 2'd2 && t != "R2") last_m_cyc = cyc;
    end
    if (adc_valid) last_valid_cyc = cyc;
  end

  // ADC model with channel-dependent latency (R11)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && adc_req) begin
        int v, lat;
        check(last_code == 14'd0 || last_code == 14'd16383, "R3", last_code, 0);
        v = (last_code == 14'd0) ? offs[ch_sel] : 16383 + gains[ch_sel];
        lat = (ch_sel == 2) ? 30 : 1 + (ch_sel % 4);
        repeat (lat) @(negedge clk);
        adc_data = 18'(v);
        adc_valid = 1;
        @(negedge clk);
        adc_valid = 0;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      offs[c] = c * 3 - 20;
      gains[c] = 10 - c * 2;
    end
    offs[0] = 16;     gains[0] = 20;
    offs[1] = -5;     gains[1] = -7;
    offs[2] = 9000;   gains[2] = -30000;
    offs[3] = -9000;  gains[3] = 20000;

    repeat (3) @(negedge clk);
    check(!wr_en && !adc_req && !done && ch_sel == 0, "R1", {wr_en, adc_req, done}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(!wr_en && !done, "R1", {wr_en, done}, 0);

    push_sweep();
    start = 1; @(negedge clk); start = 0;
    wait_done();
    check(cyc == last_m_cyc + 1, "R9", cyc, last_m_cyc + 1);
    check(exp_q.size() == 0, "R9", exp_q.size(), 0);

    repeat (40) @(negedge clk);
    check(done, "R10", done, 1);
    adc_valid = 1; adc_data = 18'sd100; @(negedge clk); adc_valid = 0;
    repeat (5) @(negedge clk);
    check(done && !wr_en && !adc_req, "R11", {done, wr_en, adc_req}, 4);

    for (int c = 0; c < NCH; c++) begin
      offs[c] = 7 - c;
      gains[c] = c - 9;
    end
    push_sweep();
    push_sweep();
    periodic = 1;
    start = 1; @(negedge clk); start = 0;
    wait_done();
    begin
      int n = 0;
      while (done) begin n++; @(negedge clk); end
      check(n == 25, "R10", n, 25);
    end
    wait_done();
    periodic = 0;
    check(exp_q.size() == 0, "R10", exp_q.size(), 0);
    repeat (30) @(negedge clk);
    check(done, "R10", done, 1);
    finish_run();
  end
endmodule